// File: doc/BRIEF.md
# Multi-Endpoint Slave FIFO Port

This block sits between an external bus master and four endpoint FIFOs. The external side drives an active-low chip select, read and write strobes, an output enable, a packet-end strobe and a 2-bit FIFO address. It moves data across a 16-bit external data bus. Each endpoint has a configuration bit that sets the width of its transfers. A byte endpoint uses bits 7:0 of the bus. A word endpoint uses all 16 bits, with the low byte on bits 7:0 and the high byte on bits 15:8. The bus is split into `data_in`, `data_out` and a per-bit `data_oe`, so that the pad ring can build the tristate driver.

Written entries sit in a pending packet and cannot be read yet. They become readable when a packet-end strobe commits the packet, or when the pending packet reaches `PKT_LEN` entries. Reads are first-word-fall-through: `data_out` always shows the oldest committed entry of the selected FIFO, and a read access removes it.

The strobes work in one of two modes. In synchronous mode every clock edge that sees a strobe high with chip select low performs one access. In asynchronous mode the strobes first pass through two-flop synchronisers. A strobe-tracking state machine then makes each rising edge of a strobe perform exactly one access, however long the strobe stays high. It has four states:

- `ST_IDLE` waits for a strobe.
- `ST_WR_HOLD`, `ST_RD_HOLD` and `ST_PE_HOLD` wait for that strobe to fall.

When the machine is in `ST_IDLE` and a synchronised strobe is seen, it performs the access and moves to the matching hold state. The write strobe is checked first, then read, then packet-end. When the strobe falls, or when the mode returns to synchronous, the hold state goes back to `ST_IDLE`.

Top module: `sfp_slave_port`

## Requirements
- R1: After reset, all four `empty` bits are 1, all `full` bits are 0, `proto_err` is 0 and `data_oe` is 0.
- R2: `fifo_addr` selects the FIFO that an access reads, writes or commits. FIFOs that are not selected keep their flags and contents.
- R3: While `cs_n` is 1, the `wr`, `rd`, `oe` and `pktend` inputs have no effect, and `data_oe` is 0.
- R4: Synchronous mode (`async_mode` = 0): each rising clock edge with `cs_n` = 0 and a strobe high performs one access, and the flags update at that edge. If several strobes are high together, write wins over read, and read wins over packet-end.
- R5: Asynchronous mode (`async_mode` = 1): each rising edge of a strobe performs exactly one access, however many cycles the strobe stays high. The access takes effect within three clock edges of the strobe rising.
- R6: `cfg_word[i]` = 1 makes FIFO i a 16-bit FIFO: bits 15:0 are stored, and `data_oe` reads 16'hFFFF while output is enabled. `cfg_word[i]` = 0 makes FIFO i a byte FIFO: only bits 7:0 are stored, `data_out[15:8]` reads 0, and `data_oe` reads 16'h00FF.
- R7: Written entries cannot be read (`empty` stays 1 for them) until a packet-end access commits them, or until the pending packet reaches `PKT_LEN` (8) entries, which commits it automatically.
- R8: A read of a FIFO with no committed data is ignored. A write to a FIFO that holds `DEPTH` (16) entries is ignored. A FIFO is never both full and empty.
- R9: A write access made while `oe` is 1 stores nothing, and it raises `proto_err` for exactly one cycle.
- R10: `data_out` shows the oldest committed entry of the selected FIFO. Successive reads return entries in the order they were written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| async_mode | input | 1 | 1 = strobes act as edges, 0 = strobes are clock enables |
| cfg_word | input | 4 | Per-FIFO width: 1 = 16-bit, 0 = 8-bit |
| cs_n | input | 1 | Active-low chip select that gates all other controls |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| oe | input | 1 | Output enable for the data bus |
| pktend | input | 1 | Packet-end strobe; commits the pending packet |
| fifo_addr | input | 2 | FIFO select |
| data_in | input | 16 | Data from the bus |
| data_out | output | 16 | Head entry of the selected FIFO |
| data_oe | output | 16 | Per-bit tristate enable for `data_out` |
| empty | output | 4 | Per-FIFO flag: no committed data |
| full | output | 4 | Per-FIFO flag: storage full |
| proto_err | output | 1 | One-cycle pulse when a write is attempted with `oe` high |

## Verification
The clocked properties cover synchronous mode only. They assume that `fifo_addr`, `data_in` and `oe` are stable during each strobe cycle. They also assume that the external master holds the address and data steady for the whole strobe window in asynchronous mode. The stimulus changes inputs only on falling clock edges. In asynchronous mode it raises each strobe one cycle after the address, holds it for four cycles, and keeps chip select low for four more cycles before releasing it. After switching modes it waits several idle cycles, so that no synchroniser still holds stale data.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_HOLD = 2'd1,
        ST_RD_HOLD = 2'd2,
        ST_PE_HOLD = 2'd3
    } strobe_state_e;

    typedef struct packed {
        logic wr;
        logic rd;
        logic pe;
        logic err;
    } access_s;

endpackage

// File: rtl/sfp_strobe_decoder.sv
module sfp_strobe_decoder
    import sfp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    async_mode,
    input  logic    cs_n,
    input  logic    rd,
    input  logic    wr,
    input  logic    oe,
    input  logic    pktend,
    output access_s acc
);

    localparam int SLAST = SYNC_STAGES - 1;

    // Strobes qualified by chip select
    logic wr_g, rd_g, pe_g, oe_g;
    assign wr_g = wr     & ~cs_n;
    assign rd_g = rd     & ~cs_n;
    assign pe_g = pktend & ~cs_n;
    assign oe_g = oe     & ~cs_n;

    // Synchronisers, only used by the asynchronous path
    logic [SYNC_STAGES-1:0] wr_sy, rd_sy, pe_sy, oe_sy;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_sy <= '0;
            rd_sy <= '0;
            pe_sy <= '0;
            oe_sy <= '0;
        end else begin
            wr_sy <= {wr_sy[SYNC_STAGES-2:0], wr_g};
            rd_sy <= {rd_sy[SYNC_STAGES-2:0], rd_g};
            pe_sy <= {pe_sy[SYNC_STAGES-2:0], pe_g};
            oe_sy <= {oe_sy[SYNC_STAGES-2:0], oe_g};
        end
    end

    logic wr_s, rd_s, pe_s, oe_s;
    assign wr_s = wr_sy[SLAST];
    assign rd_s = rd_sy[SLAST];
    assign pe_s = pe_sy[SLAST];
    assign oe_s = oe_sy[SLAST];

    strobe_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (async_mode) begin
                    if (wr_s)      state_d = ST_WR_HOLD;
                    else if (rd_s) state_d = ST_RD_HOLD;
                    else if (pe_s) state_d = ST_PE_HOLD;
                end
            end
            ST_WR_HOLD: if (!wr_s || !async_mode) state_d = ST_IDLE;
            ST_RD_HOLD: if (!rd_s || !async_mode) state_d = ST_IDLE;
            ST_PE_HOLD: if (!pe_s || !async_mode) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Output decode: one access per cycle, write > read > packet-end
    always_comb begin
        acc = '0;
        if (!async_mode) begin
            if (wr_g) begin
                acc.err = oe_g;
                acc.wr  = ~oe_g;
            end else if (rd_g) begin
                acc.rd = 1'b1;
            end else if (pe_g) begin
                acc.pe = 1'b1;
            end
        end else if (state_q == ST_IDLE) begin
            if (wr_s) begin
                acc.err = oe_s;
                acc.wr  = ~oe_s;
            end else if (rd_s) begin
                acc.rd = 1'b1;
            end else if (pe_s) begin
                acc.pe = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sfp_ep_fifo.sv
module sfp_ep_fifo #(
    parameter int DW      = 16,
    parameter int DEPTH   = 16,
    parameter int PKT_LEN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          commit,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full
);

    localparam int          AW      = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);
    localparam logic [AW:0] PKT_W   = (AW+1)'(PKT_LEN);

    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   wr_ptr, rd_ptr, cm_ptr;
    logic [AW:0]   total, ready, wr_nxt, pend_nxt;
    logic          push_ok, pop_ok;

    assign total    = wr_ptr - rd_ptr;
    assign ready    = cm_ptr - rd_ptr;
    assign full     = (total == DEPTH_W);
    assign empty    = (ready == '0);
    assign push_ok  = push & ~full;
    assign pop_ok   = pop & ~empty;
    assign wr_nxt   = wr_ptr + (AW+1)'(push_ok);
    assign pend_nxt = wr_nxt - cm_ptr;
    assign dout     = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr[AW-1:0]] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cm_ptr <= '0;
        end else begin
            wr_ptr <= wr_nxt;
            if (pop_ok) rd_ptr <= rd_ptr + 1'b1;
            if (commit || pend_nxt == PKT_W) cm_ptr <= wr_nxt;
        end
    end

endmodule

// File: rtl/sfp_slave_port.sv
module sfp_slave_port
    import sfp_pkg::*;
#(
    parameter int NUM_EP  = 4,
    parameter int DW      = 16,
    parameter int DEPTH   = 16,
    parameter int PKT_LEN = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      async_mode,
    input  logic [NUM_EP-1:0]         cfg_word,
    input  logic                      cs_n,
    input  logic                      rd,
    input  logic                      wr,
    input  logic                      oe,
    input  logic                      pktend,
    input  logic [$clog2(NUM_EP)-1:0] fifo_addr,
    input  logic [DW-1:0]             data_in,
    output logic [DW-1:0]             data_out,
    output logic [DW-1:0]             data_oe,
    output logic [NUM_EP-1:0]         empty,
    output logic [NUM_EP-1:0]         full,
    output logic                      proto_err
);

    localparam int HW = DW / 2;

    access_s       acc;
    logic [DW-1:0] head [NUM_EP];
    logic [DW-1:0] sel_head;

    sfp_strobe_decoder #(.SYNC_STAGES(2)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_mode (async_mode),
        .cs_n       (cs_n),
        .rd         (rd),
        .wr         (wr),
        .oe         (oe),
        .pktend     (pktend),
        .acc        (acc)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic          hit;
        logic [DW-1:0] wdata;
        assign hit   = (fifo_addr == i);
        assign wdata = cfg_word[i] ? data_in : {{HW{1'b0}}, data_in[HW-1:0]};

        sfp_ep_fifo #(.DW(DW), .DEPTH(DEPTH), .PKT_LEN(PKT_LEN)) u_fifo (
            .clk    (clk),
            .rst_n  (rst_n),
            .push   (acc.wr & hit),
            .pop    (acc.rd & hit),
            .commit (acc.pe & hit),
            .din    (wdata),
            .dout   (head[i]),
            .empty  (empty[i]),
            .full   (full[i])
        );
    end

    always_comb begin
        sel_head = head[fifo_addr];
        data_out = cfg_word[fifo_addr] ? sel_head : {{HW{1'b0}}, sel_head[HW-1:0]};
        if (!cs_n && oe) data_oe = cfg_word[fifo_addr] ? '1 : {{HW{1'b0}}, {HW{1'b1}}};
        else             data_oe = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) proto_err <= 1'b0;
        else        proto_err <= acc.err;
    end

endmodule

// File: rtl/sfp_slave_port_chk.sv
module sfp_slave_port_chk #(
    parameter int NUM_EP = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      async_mode,
    input logic                      cs_n,
    input logic                      rd,
    input logic                      wr,
    input logic                      oe,
    input logic [$clog2(NUM_EP)-1:0] fifo_addr,
    input logic [NUM_EP-1:0]         empty,
    input logic [NUM_EP-1:0]         full,
    input logic                      proto_err
);

    AST_DESELECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!async_mode && cs_n) |=> ($stable(empty) && $stable(full))); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!async_mode && !cs_n && wr && !oe && full[fifo_addr]) |=> full[$past(fifo_addr)]); // R8

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!async_mode && !cs_n && rd && !wr && empty[fifo_addr]) |=> empty[$past(fifo_addr)]); // R8

    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ((full & empty) == '0)); // R8

    AST_OE_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (!async_mode && !cs_n && wr && oe) |=> proto_err); // R9

    AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!async_mode && !(wr && !cs_n && oe)) |=> !proto_err); // R9

endmodule

bind sfp_slave_port sfp_slave_port_chk #(.NUM_EP(NUM_EP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_mode (async_mode),
    .cs_n       (cs_n),
    .rd         (rd),
    .wr         (wr),
    .oe         (oe),
    .fifo_addr  (fifo_addr),
    .empty      (empty),
    .full       (full),
    .proto_err  (proto_err)
);

// File: tb/sfp_slave_port_tb.sv
module sfp_slave_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int PKT        = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        async_mode = 1'b0;
    logic [3:0]  cfg_word = 4'b0101;
    logic        cs_n = 1'b1, rd = 1'b0, wr = 1'b0, oe = 1'b0, pktend = 1'b0;
    logic [1:0]  fifo_addr = '0;
    logic [15:0] data_in = '0;
    logic [15:0] data_out, data_oe;
    logic [3:0]  empty, full;
    logic        proto_err;

    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfp_slave_port u_dut (
        .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .cfg_word(cfg_word),
        .cs_n(cs_n), .rd(rd), .wr(wr), .oe(oe), .pktend(pktend),
        .fifo_addr(fifo_addr), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .empty(empty), .full(full), .proto_err(proto_err)
    );

    // Reference model
    logic [15:0] mdl [4][DEPTH];
    int wp[4], rp[4], cp[4];

    // Scoreboard
    logic [15:0] exp_q[$];
    logic [15:0] oe_q[$];
    event        rd_ev;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(rd_ev);
            begin
                logic [15:0] e, eo;
                e  = exp_q.pop_front();
                eo = oe_q.pop_front();
                check(data_out == e, "R10 read data", 32'(data_out), 32'(e));
                check(data_oe == eo, "R6 data_oe width", 32'(data_oe), 32'(eo));
            end
        end
    end

    function automatic void mdl_write(input int f, input logic [15:0] d);
        if (wp[f] - rp[f] == DEPTH) return;
        mdl[f][wp[f] % DEPTH] = cfg_word[f] ? d : {8'h00, d[7:0]};
        wp[f]++;
        if (wp[f] - cp[f] == PKT) cp[f] = wp[f];
    endfunction

    // kind: 0 write, 1 read, 2 packet-end, 3 write and read together
    task automatic do_acc(input int kind, input int f, input logic [15:0] d, input bit oe_v);
        bit take;
        take = (kind == 1) && (cp[f] != rp[f]);
        if (take) begin
            exp_q.push_back(mdl[f][rp[f] % DEPTH]);
            oe_q.push_back(oe_v ? (cfg_word[f] ? 16'hFFFF : 16'h00FF) : 16'h0000);
        end
        @(negedge clk);
        cs_n = 1'b0; fifo_addr = 2'(f); data_in = d; oe = oe_v;
        if (async_mode) @(negedge clk);
        wr = (kind == 0 || kind == 3);
        rd = (kind == 1 || kind == 3);
        pktend = (kind == 2);
        #1;
        if (take) -> rd_ev;
        if (async_mode) begin
            repeat (4) @(negedge clk);
            wr = 0; rd = 0; pktend = 0;
            repeat (4) @(negedge clk);
        end else begin
            @(negedge clk);
            wr = 0; rd = 0; pktend = 0;
            if ((kind == 0 || kind == 3) && oe_v)
                check(proto_err == 1'b1, "R9 proto_err pulse", 32'(proto_err), 32'd1);
        end
        cs_n = 1'b1; oe = 1'b0;
        if (kind == 0 && !oe_v) mdl_write(f, d);
        if (kind == 3) mdl_write(f, d);
        if (kind == 2) cp[f] = wp[f];
        if (take) rp[f]++;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin wp[i] = 0; rp[i] = 0; cp[i] = 0; end
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check(empty == 4'hF, "R1 empty after reset", 32'(empty), 32'hF);
        check(full == 4'h0, "R1 full after reset", 32'(full), 0);
        check(proto_err == 1'b0, "R1 proto_err after reset", 32'(proto_err), 0);
        check(data_oe == 16'h0, "R1 data_oe after reset", 32'(data_oe), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7 pending data is not readable
        do_acc(0, 0, 16'hA1B2, 0);
        do_acc(0, 0, 16'hC3D4, 0);
        do_acc(0, 0, 16'hE5F6, 0);
        check(empty[0] == 1'b1, "R7 uncommitted hidden", 32'(empty[0]), 1);
        // R2 / R7 packet-end commits the selected FIFO only
        do_acc(2, 0, 16'h0, 0);
        check(empty == 4'hE, "R2 R7 commit selects FIFO 0", 32'(empty), 32'hE);
        // R6 word reads, R10 order
        for (int i = 0; i < 3; i++) do_acc(1, 0, 16'h0, 1);
        check(empty[0] == 1'b1, "R10 drained", 32'(empty[0]), 1);

        // R6 byte FIFO
        do_acc(0, 1, 16'h12AB, 0);
        do_acc(0, 1, 16'h34CD, 0);
        do_acc(2, 1, 16'h0, 0);
        do_acc(1, 1, 16'h0, 1);
        do_acc(1, 1, 16'h0, 1);

        // R3 deselected strobes ignored
        @(negedge clk);
        cs_n = 1'b1; fifo_addr = 2'd2; data_in = 16'h5555; wr = 1'b1; oe = 1'b1; pktend = 1'b1;
        #1;
        check(data_oe == 16'h0, "R3 data_oe while deselected", 32'(data_oe), 0);
        @(negedge clk); wr = 0; oe = 0; pktend = 0;
        do_acc(2, 2, 16'h0, 0);
        check(empty[2] == 1'b1, "R3 deselected write ignored", 32'(empty[2]), 1);

        // R9 write with oe
        do_acc(0, 2, 16'h7777, 1);
        do_acc(2, 2, 16'h0, 0);
        check(empty[2] == 1'b1, "R9 oe write not stored", 32'(empty[2]), 1);

        // R7 auto commit at PKT entries
        for (int i = 0; i < PKT; i++) do_acc(0, 2, 16'(16'h1000 + i), 0);
        check(empty[2] == 1'b0, "R7 auto commit", 32'(empty[2]), 0);
        for (int i = PKT; i < DEPTH; i++) do_acc(0, 2, 16'(16'h1000 + i), 0);
        check(full[2] == 1'b1, "R8 full at depth", 32'(full[2]), 1);
        do_acc(0, 2, 16'hDEAD, 0);
        check(full[2] == 1'b1, "R8 write to full", 32'(full[2]), 1);
        for (int i = 0; i < DEPTH; i++) do_acc(1, 2, 16'h0, 0);
        check(empty[2] == 1'b1 && full[2] == 1'b0, "R8 drained", 32'({full[2], empty[2]}), 32'b01);
        do_acc(1, 2, 16'h0, 0);
        check(empty[2] == 1'b1, "R8 read of empty ignored", 32'(empty[2]), 1);
        do_acc(0, 2, 16'hBEEF, 0);
        do_acc(2, 2, 16'h0, 0);
        do_acc(1, 2, 16'h0, 1);

        // R4 write wins over read
        do_acc(3, 3, 16'h99C7, 0);
        check(empty[3] == 1'b1, "R4 write wins over read", 32'(empty[3]), 1);
        do_acc(2, 3, 16'h0, 0);
        do_acc(1, 3, 16'h0, 1);

        // R5 asynchronous mode
        @(negedge clk); async_mode = 1'b1;
        repeat (4) @(negedge clk);
        do_acc(0, 1, 16'h0042, 0);
        check(empty[1] == 1'b1, "R5 async write pending", 32'(empty[1]), 1);
        do_acc(2, 1, 16'h0, 0);
        check(empty[1] == 1'b0, "R5 async commit", 32'(empty[1]), 0);
        do_acc(1, 1, 16'h0, 1);
        check(empty[1] == 1'b1, "R5 one access per long strobe", 32'(empty[1]), 1);
        do_acc(0, 0, 16'h8421, 0);
        do_acc(0, 0, 16'h1248, 0);
        do_acc(2, 0, 16'h0, 0);
        do_acc(1, 0, 16'h0, 1);
        do_acc(1, 0, 16'h0, 1);
        check(empty[0] == 1'b1, "R5 async drained", 32'(empty[0]), 1);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10 scoreboard drained", 32'(exp_q.size()), 0);
        summary();
        $finish;
    end

endmodule